// File: doc/BRIEF.md
# Video Pixel Level Limiter and Long-Word Packer

This block takes one scaled pixel per clock as three 8-bit components. They are Y, U, V for the luminance/chroma formats and R, G, B for the colour formats. The block first conditions the levels. Colour components are clamped into the legal 8-bit range. Luminance can optionally be held inside the studio video range. Chroma can be emitted either as straight binary or as two's complement. In the 16-bit colour format each component is cut down to 5 bits.

The conditioned pixels are then packed into 32-bit long words for a downstream output buffer. Four packing formats are available: one 32-bit colour pixel per word, two 16-bit colour pixels per word, two 16-bit luminance/chroma pixels per word, or four 8-bit greyscale pixels per word. A 2-bit position control has two uses. It chooses the slot of the first pixel of each line, and in the luminance/chroma format it also swaps the chroma order from U,V to V,U. Slots left empty ahead of the first pixel, or after the last pixel of a line, carry fill values that depend on the format. A word leaves the block with a one-cycle valid strobe once its last slot is written or the line ends.

Top module: `vid_pixel_packer`

## Requirements
- R1: In the 32-bit colour format (fmt=0) the word is {8'd1, R, G, B}, with R in bits 23:16, G in 15:8 and B in 7:0. Each of R, G and B is the input clamped to the range 1..254.
- R2: In the luminance/chroma (fmt=2) and greyscale (fmt=3) formats, a set luma-limit input clamps Y to 16..235. A clear luma-limit input passes Y through unchanged, including 0 and 255.
- R3: In the 16-bit colour format (fmt=1) each pixel half-word is {1'b0, R[7:3], G[7:3], B[7:3]}, formed after the R1 clamp.
- R4: In fmt=2 a set chroma-format input inverts the MSB of the chroma byte (two's complement). A clear input emits straight binary.
- R5: In fmt=2 each half-word is {C, Y}, with C in the upper byte. In fmt=3, greyscale slot k occupies bits 8k+7:8k. Slot 0 is the least significant in every format.
- R6: At a line start the first pixel goes to slot pos in fmt=3, to slot pos[1] in fmt=1 and fmt=2, and to slot 0 in fmt=0. Every later pixel of the line takes the next slot.
- R7: In fmt=2 a pixel in slot s carries U (component 1) when s XOR pos[0] is 0, and V (component 2) otherwise. With pos=0 and an odd line length, the incomplete chroma pair therefore sits at the line end. With pos=2 it sits at the line start.
- R8: A word is emitted, with word_valid high for one cycle, exactly in the cycle after the clock edge that takes the pixel filling its last slot or the line's last pixel. No other cycle has word_valid high.
- R9: The pixel marked as line end always closes the current word, even when that word is only partly filled.
- R10: Empty slots carry fill values. In fmt=1 the fill half-word is 16'h0000. In fmt=2 the fill half-word has Y=1 and C=128 (straight binary) or C=1 (two's complement). In fmt=3 the fill byte is 254.
- R11: After reset word_valid is 0 and word_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_eol | input | 1 | Pixel is the last of a line |
| pix_c0 | input | 8 | Component 0: Y or R |
| pix_c1 | input | 8 | Component 1: U or G |
| pix_c2 | input | 8 | Component 2: V or B |
| cfg_fmt | input | 2 | Packing format: 0 colour32, 1 colour16, 2 luma/chroma16, 3 grey8 |
| cfg_pos | input | 2 | First-slot position / chroma order control |
| cfg_luma_lim | input | 1 | Restrict luminance to 16..235 |
| cfg_chroma_tc | input | 1 | Two's-complement chroma |
| word_valid | output | 1 | Long word valid strobe |
| word_data | output | 32 | Packed long word |

## Verification
The bench aims at the extreme values 0 and 255, which a clamp that is off by one or missing lets through unchanged into the word. Odd-length luminance/chroma lines under both positions 0 and 2 are included. A design that inverts the chroma order, or misplaces the first pixel, would put U and V in the wrong halves there, or put the fill half at the wrong end. Greyscale lines start at every position with every remainder length. Wrong start-slot logic or a missed line-end flush shows up as displaced bytes, a missing word or a stale byte where fill belongs. Random lines with changing configuration and idle gaps inside lines check that no word is emitted early, late or twice.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
   typedef enum logic [1:0] {
      FMT_RGB32 = 2'd0,
      FMT_RGB16 = 2'd1,
      FMT_YUV16 = 2'd2,
      FMT_MONO8 = 2'd3
   } vpk_fmt_e;

   // log2 of the pixel slots per long word
   function automatic logic [1:0] slots_lg(vpk_fmt_e f);
      case (f)
         FMT_RGB32: return 2'd0;
         FMT_MONO8: return 2'd2;
         default:   return 2'd1;
      endcase
   endfunction
endpackage

// File: rtl/vpk_level.sv
module vpk_level
   import vpk_pkg::*;
#(
   parameter int CW              = 8,
   parameter int TRUNC_W         = 5,
   parameter int RGB_MIN         = 1,
   parameter int RGB_MAX         = 254,
   parameter int LUMA_MIN        = 16,
   parameter int LUMA_MAX        = 235,
   parameter int FILL_RGB        = 1,
   parameter int FILL_LUMA       = 1,
   parameter int FILL_CHROMA_BIN = 128,
   parameter int FILL_CHROMA_TC  = 1,
   parameter int FILL_GREY       = 254
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   c0,
   input  logic [CW-1:0]   c1,
   input  logic [CW-1:0]   c2,
   input  vpk_fmt_e        fmt,
   input  logic            luma_lim,
   input  logic            chroma_tc,
   input  logic            use_v,
   output logic [4*CW-1:0] lane,
   output logic [4*CW-1:0] fill
);
   localparam int WW = 4 * CW;

   function automatic logic [CW-1:0] clamp(logic [CW-1:0] v, int lo, int hi);
      if (int'(v) < lo) return CW'(lo);
      if (int'(v) > hi) return CW'(hi);
      return v;
   endfunction

   logic [CW-1:0] r_c, g_c, b_c, y_c, c_sel, c_out, c_fill;
   logic [CW-1:0] rgb_fill_b;

   always_comb begin
      r_c   = clamp(c0, RGB_MIN, RGB_MAX);
      g_c   = clamp(c1, RGB_MIN, RGB_MAX);
      b_c   = clamp(c2, RGB_MIN, RGB_MAX);
      y_c   = luma_lim ? clamp(c0, LUMA_MIN, LUMA_MAX) : c0;
      c_sel = use_v ? c2 : c1;
      c_out = chroma_tc ? {~c_sel[CW-1], c_sel[CW-2:0]} : c_sel;
      c_fill     = chroma_tc ? CW'(FILL_CHROMA_TC) : CW'(FILL_CHROMA_BIN);
      rgb_fill_b = CW'(FILL_RGB);
   end

   always_comb begin
      lane = '0;
      fill = '0;
      case (fmt)
         FMT_RGB32: begin
            lane = {rgb_fill_b, r_c, g_c, b_c};
            fill = {4{rgb_fill_b}};
         end
         FMT_RGB16: begin
            lane[3*TRUNC_W-1:0] = {r_c[CW-1 -: TRUNC_W], g_c[CW-1 -: TRUNC_W],
                                   b_c[CW-1 -: TRUNC_W]};
            for (int h = 0; h < 2; h++)
               fill[h*2*CW +: 3*TRUNC_W] = {3{rgb_fill_b[CW-1 -: TRUNC_W]}};
         end
         FMT_YUV16: begin
            lane[2*CW-1:0] = {c_out, y_c};
            fill = {2{c_fill, CW'(FILL_LUMA)}};
         end
         default: begin
            lane[CW-1:0] = y_c;
            fill = {4{CW'(FILL_GREY)}};
         end
      endcase
   end

   AST_RGB_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_RGB32) |-> (int'(lane[CW-1:0]) >= RGB_MIN && int'(lane[CW-1:0]) <= RGB_MAX
                              && int'(lane[2*CW +: CW]) >= RGB_MIN && int'(lane[2*CW +: CW]) <= RGB_MAX)); // R1
   AST_LUMA_LIMITED: assert property (@(posedge clk) disable iff (!rst_n)
      (luma_lim && (fmt == FMT_YUV16 || fmt == FMT_MONO8))
        |-> (int'(lane[CW-1:0]) >= LUMA_MIN && int'(lane[CW-1:0]) <= LUMA_MAX)); // R2
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt != FMT_RGB32) |-> (lane[WW-1:2*CW] == '0)); // R5
endmodule

// File: rtl/vpk_pack.sv
module vpk_pack
   import vpk_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pix_valid,
   input  logic            pix_sol,
   input  logic            pix_eol,
   input  vpk_fmt_e        fmt,
   input  logic [1:0]      pos,
   input  logic [4*CW-1:0] lane,
   input  logic [4*CW-1:0] fill,
   output logic [1:0]      slot,
   output logic            word_valid,
   output logic [4*CW-1:0] word_data
);
   localparam int WW    = 4 * CW;
   localparam int LANES = 4;

   logic [WW-1:0]    acc_q, acc_ins, lane_mask, composed;
   logic [LANES-1:0] mask_q, mask_ins, byte_on;
   logic [1:0]       ptr_q, start, lg, last_slot;
   logic             last;
   int               shift;

   always_comb begin
      lg = slots_lg(fmt);
      case (fmt)
         FMT_RGB32: start = 2'd0;
         FMT_MONO8: start = pos;
         default:   start = {1'b0, pos[1]};
      endcase
      last_slot = 2'((1 << lg) - 1);
      slot      = pix_sol ? start : ptr_q;
      shift     = int'(slot) * (WW >> lg);
      lane_mask = '1 >> (WW - (WW >> lg));
      acc_ins   = (acc_q & ~(lane_mask << shift)) | ((lane & lane_mask) << shift);
      mask_ins  = (pix_sol ? '0 : mask_q) | (LANES'(1) << slot);
      last      = (slot == last_slot) || pix_eol;
   end

   for (genvar b = 0; b < LANES; b++) begin : g_byte
      assign byte_on[b] = mask_ins[b >> (2 - lg)];
      assign composed[b*CW +: CW] = byte_on[b] ? acc_ins[b*CW +: CW] : fill[b*CW +: CW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         mask_q     <= '0;
         ptr_q      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         word_valid <= 1'b0;
         if (pix_valid) begin
            if (last) begin
               word_valid <= 1'b1;
               word_data  <= composed;
               mask_q     <= '0;
               ptr_q      <= '0;
            end else begin
               acc_q  <= acc_ins;
               mask_q <= mask_ins;
               ptr_q  <= slot + 2'd1;
            end
         end
      end
   end

   AST_WORD_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(pix_valid)); // R8
   AST_EOL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_eol) |=> word_valid); // R9
   AST_EMPTY_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (mask_q == '0 && ptr_q == 2'd0)); // R8
   AST_SLOT_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_sol) |-> (slot <= last_slot)); // R6
endmodule

// File: rtl/vid_pixel_packer.sv
module vid_pixel_packer
   import vpk_pkg::*;
#(
   parameter int CW       = 8,
   parameter int TRUNC_W  = 5,
   parameter int RGB_MIN  = 1,
   parameter int RGB_MAX  = 254,
   parameter int LUMA_MIN = 16,
   parameter int LUMA_MAX = 235,
   localparam int WW      = 4 * CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   input  logic          pix_sol,
   input  logic          pix_eol,
   input  logic [CW-1:0] pix_c0,
   input  logic [CW-1:0] pix_c1,
   input  logic [CW-1:0] pix_c2,
   input  logic [1:0]    cfg_fmt,
   input  logic [1:0]    cfg_pos,
   input  logic          cfg_luma_lim,
   input  logic          cfg_chroma_tc,
   output logic          word_valid,
   output logic [WW-1:0] word_data
);
   initial begin
      assert (CW >= 4) else $error("component width too small");
      assert (3 * TRUNC_W + 1 <= 2 * CW && TRUNC_W <= CW) else $error("truncated pixel exceeds half word");
      assert (RGB_MIN <= RGB_MAX && RGB_MAX < (1 << CW)) else $error("bad colour range");
      assert (LUMA_MIN <= LUMA_MAX && LUMA_MAX < (1 << CW)) else $error("bad luma range");
   end

   vpk_fmt_e      fmt;
   logic [1:0]    slot;
   logic [WW-1:0] lane, fill;
   logic          use_v;

   assign fmt   = vpk_fmt_e'(cfg_fmt);
   assign use_v = slot[0] ^ cfg_pos[0];

   vpk_level #(
      .CW(CW), .TRUNC_W(TRUNC_W), .RGB_MIN(RGB_MIN), .RGB_MAX(RGB_MAX),
      .LUMA_MIN(LUMA_MIN), .LUMA_MAX(LUMA_MAX)
   ) u_level (
      .clk(clk), .rst_n(rst_n),
      .c0(pix_c0), .c1(pix_c1), .c2(pix_c2),
      .fmt(fmt), .luma_lim(cfg_luma_lim), .chroma_tc(cfg_chroma_tc),
      .use_v(use_v), .lane(lane), .fill(fill)
   );

   vpk_pack #(.CW(CW)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_eol(pix_eol),
      .fmt(fmt), .pos(cfg_pos), .lane(lane), .fill(fill),
      .slot(slot), .word_valid(word_valid), .word_data(word_data)
   );
endmodule

// File: tb/tb_vid_pixel_packer.sv
`timescale 1ns/1ps
module tb_vid_pixel_packer;
   logic clk = 1'b0, rst_n = 1'b0;
   logic pix_valid = 0, pix_sol = 0, pix_eol = 0;
   logic [7:0] pix_c0 = 0, pix_c1 = 0, pix_c2 = 0;
   logic [1:0] cfg_fmt = 0, cfg_pos = 0;
   logic cfg_luma_lim = 0, cfg_chroma_tc = 0;
   logic word_valid;
   logic [31:0] word_data;

   int n_checks = 0, n_fail = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];
   string tag = "R5";

   // reference packing state
   logic [7:0] m_byte[4];
   logic       m_on[4];
   int         m_ptr = 0;

   always #2.5 clk = ~clk;

   vid_pixel_packer dut (.*);

   function automatic logic [7:0] lim(logic [7:0] v, int lo, int hi);
      return (v < lo) ? 8'(lo) : (v > hi) ? 8'(hi) : v;
   endfunction

   function automatic int nslots(int f);
      return (f == 0) ? 1 : (f == 3) ? 4 : 2;
   endfunction

   // value written into a slot, lsb first
   function automatic logic [31:0] ref_pix(int f, int s, logic [7:0] a, logic [7:0] b, logic [7:0] c,
                                           int p, logic ll, logic tc);
      logic [7:0] y, ch;
      y = ll ? lim(a, 16, 235) : a;
      case (f)
         0: return {8'd1, lim(a,1,254), lim(b,1,254), lim(c,1,254)};
         1: return {16'd0, 1'b0, lim(a,1,254) >> 3, 5'(lim(b,1,254) >> 3), 5'(lim(c,1,254) >> 3)};
         2: begin
            ch = (((s % 2) ^ (p % 2)) == 0) ? b : c;
            if (tc) ch = ch ^ 8'h80;
            return {16'd0, ch, y};
         end
         default: return {24'd0, y};
      endcase
   endfunction

   function automatic logic [7:0] ref_fill(int f, int byte_i, logic tc);
      case (f)
         1: return 8'h00;
         2: return (byte_i % 2 == 0) ? 8'd1 : (tc ? 8'd1 : 8'd128);
         3: return 8'd254;
         default: return 8'd1;
      endcase
   endfunction

   task automatic check(string t, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", t, act, exp);
      end
   endtask

   task automatic model_pixel(logic sol, logic eol, logic [7:0] a, logic [7:0] b, logic [7:0] c);
      int f, p, s, n, bps;
      logic [31:0] v, w;
      f = int'(cfg_fmt); p = int'(cfg_pos); n = nslots(f); bps = 4 / n;
      if (sol) begin
         for (int k = 0; k < 4; k++) m_on[k] = 1'b0;
         m_ptr = (f == 0) ? 0 : (f == 3) ? p : p / 2;
      end
      s = m_ptr;
      v = ref_pix(f, s, a, b, c, p, cfg_luma_lim, cfg_chroma_tc);
      for (int j = 0; j < bps; j++) begin
         m_byte[s*bps + j] = v[j*8 +: 8];
         m_on[s*bps + j]   = 1'b1;
      end
      m_ptr = s + 1;
      if (s == n - 1 || eol) begin
         for (int k = 0; k < 4; k++)
            w[k*8 +: 8] = m_on[k] ? m_byte[k] : ref_fill(f, k, cfg_chroma_tc);
         exp_q.push_back(w);
         tag_q.push_back(tag);
         for (int k = 0; k < 4; k++) m_on[k] = 1'b0;
         m_ptr = 0;
      end
   endtask

   task automatic drive_pixel(logic sol, logic eol, logic [7:0] a, logic [7:0] b, logic [7:0] c);
      @(negedge clk);
      pix_valid = 1; pix_sol = sol; pix_eol = eol;
      pix_c0 = a; pix_c1 = b; pix_c2 = c;
      model_pixel(sol, eol, a, b, c);
      @(negedge clk);
      pix_valid = 0; pix_sol = 0; pix_eol = 0;
   endtask

   task automatic set_cfg(int f, int p, logic ll, logic tc);
      @(negedge clk);
      cfg_fmt = 2'(f); cfg_pos = 2'(p); cfg_luma_lim = ll; cfg_chroma_tc = tc;
   endtask

   // one line; values from list if given, else random
   task automatic line(int len, logic [7:0] vals[$]);
      logic [7:0] a, b, c;
      for (int i = 0; i < len; i++) begin
         if (vals.size() > 0) begin
            a = vals[i % vals.size()]; b = vals[(i+1) % vals.size()]; c = vals[(i+2) % vals.size()];
         end else begin
            a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
         end
         if (vals.size() == 0 && $urandom_range(0, 3) == 0) @(negedge clk);
         drive_pixel(i == 0, i == len - 1, a, b, c);
      end
      repeat (2) @(negedge clk);
   endtask

   // output monitor
   always @(negedge clk) begin
      if (rst_n && word_valid) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R8: unexpected word %08h, expected none", word_data);
         end else begin
            check(tag_q.pop_front(), word_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] ext[$];
      logic [7:0] none[$];
      ext = '{8'd0, 8'd255, 8'd128, 8'd1, 8'd254, 8'd16, 8'd235, 8'd15, 8'd236};
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R11 valid", {31'd0, word_valid}, 32'd0);
      check("R11 data", word_data, 32'd0);
      rst_n = 1;

      tag = "R1";  set_cfg(0, 2, 0, 0); line(5, ext);
      tag = "R3";  set_cfg(1, 0, 0, 0); line(6, ext);
      tag = "R2";  set_cfg(3, 0, 1, 0); line(9, ext);
      tag = "R2";  set_cfg(2, 0, 1, 0); line(8, ext);
      tag = "R2";  set_cfg(3, 0, 0, 0); line(8, ext);
      tag = "R4";  set_cfg(2, 0, 0, 1); line(4, ext);
      tag = "R7";  set_cfg(2, 1, 0, 0); line(4, ext);
      tag = "R7";  set_cfg(2, 3, 0, 1); line(5, ext);
      tag = "R10"; set_cfg(2, 0, 0, 0); line(5, ext);
      tag = "R10"; set_cfg(2, 2, 0, 1); line(5, ext);
      tag = "R10"; set_cfg(1, 2, 0, 0); line(3, ext);
      for (int p = 0; p < 4; p++)
         for (int l = 1; l <= 5; l++) begin
            tag = "R6"; set_cfg(3, p, 0, 0); line(l, ext);
         end
      tag = "R9"; set_cfg(3, 0, 1, 0); line(1, ext);
      tag = "R9"; set_cfg(2, 0, 0, 1); line(1, ext);

      for (int n = 0; n < 250; n++) begin
         tag = "R5";
         set_cfg($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom));
         line($urandom_range(1, 11), none);
      end

      repeat (5) @(negedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R8: %0d words missing, expected 0", exp_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule